// File: doc/BRIEF.md
# Framed Serial Command Decoder

This block is the slave side of a slow serial programming port. A host frames each session with a chip-select line, clocks bits on a separate serial clock, and uses one bidirectional data pin. All three pins are brought into the fast system clock through two-flop synchronizers. Edges are found by comparing each synchronized sample with the one before it. The port stays locked after every chip-select rise until a six-bit unlock preamble arrives. The preamble also carries a flag that decides whether the next chip-select rise triggers a reload of the configuration and converter registers from non-volatile memory.

Once unlocked, the block shifts in 16-bit control words back to back, least significant bit first. Each word is split into a 12-bit data field and a 4-bit command code. The code is turned into a one-cycle strobe, with address or data, toward a bit-addressed memory controller or toward a register bank. After a read command, the data pin turns around: after a programmable delay it drives the addressed memory bit until chip select falls. The pin tri-state is modelled as an output value plus an output enable.

Top module: `sercmd_decoder`

## Requirements
- R1: After reset, every strobe, `session_o`, `dio_oe_o` and `dio_o` are low.
- R2: After each chip-select rise, the first six bits, in arrival order, must be 1,0,1,0,U,0. If they are not, every later bit of that session is ignored: no strobe is issued and `session_o` stays low.
- R3: On a chip-select rise, `reload_o` pulses for one cycle unless the most recent valid preamble had U=1. After reset, the first rise produces a reload.
- R4: Words are 16 bits, sent LSB first. Bits 0 to 11 are data and bits 12 to 15 are the command code. Words follow each other with no re-framing.
- R5: Code 1h pulses `mem_erase_o`. Code 2h pulses `mem_set_o` (begin bit write). Code 5h pulses `mem_clr_o` (end bit write). For these commands `mem_addr_o` carries data bits 0 to 6, and data bits 7 to 11 have no effect.
- R6: Codes 8h, 9h, Ah, Bh and Ch pulse `reg_wr_o` with `reg_idx_o` = 0, 1, 2, 3, 4 and with the 12-bit data field on `reg_data_o`. Codes 6h, 7h, Dh, Eh and Fh pulse `reg_load_o`.
- R7: Codes 0h and 4h produce no strobe.
- R8: Code 3h pulses `mem_rd_o` with the address. Some RD_DLY system cycles after the next synchronized serial-clock fall, `dio_oe_o` rises and `dio_o` presents `mem_bit_i`. Before that point `dio_oe_o` stays low.
- R9: When chip select goes low, `dio_oe_o` and `session_o` drop, and a partially received word is discarded.
- R10: `session_o` is high from a valid preamble until chip select falls.
- R11: At most one strobe is high in any cycle, and each strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from host |
| cs_i | input | 1 | Chip select, high selects |
| dio_i | input | 1 | Data pin input value |
| mem_bit_i | input | 1 | Memory bit at `mem_addr_o` |
| dio_o | output | 1 | Data pin output value |
| dio_oe_o | output | 1 | Data pin output enable |
| session_o | output | 1 | Unlocked session active |
| reload_o | output | 1 | Reload-from-memory strobe |
| mem_erase_o | output | 1 | Erase-all strobe |
| mem_set_o | output | 1 | Begin bit write strobe |
| mem_clr_o | output | 1 | End bit write strobe |
| mem_rd_o | output | 1 | Bit read strobe |
| mem_addr_o | output | 7 | Bit address of last memory command |
| reg_wr_o | output | 1 | Register write strobe |
| reg_idx_o | output | 3 | Register index 0..4 |
| reg_data_o | output | 12 | Register write data |
| reg_load_o | output | 1 | Register load strobe |

## Verification
The word stream is driven with every command code, including the no-operation and reserved ones. It uses data fields with the upper address bits set, so that address truncation and wrong field splitting are told apart. Corrupt preambles and words truncated by chip select show whether locking and discarding work. Sessions with the flag set and cleared separate the reload decision from the chip-select edge itself. Reads of a set bit and of a cleared bit are sampled before and after the turnaround delay, which separates turnaround timing from data value.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;
  typedef enum logic [2:0] {
    F_IDLE, F_PRE, F_WORD, F_DEAD, F_HOLD
  } frame_st_t;

  typedef enum logic [3:0] {
    K_NONE, K_ERASE, K_SET, K_READ, K_CLR, K_REG, K_LOAD
  } cmd_kind_t;

  localparam int WORD_W = 16;
  localparam int DATA_W = 12;
  localparam int CODE_W = 4;
  localparam int ADDR_W = 7;
  localparam int PRE_W  = 6;

  function automatic cmd_kind_t classify(input logic [CODE_W-1:0] code);
    case (code)
      4'h1: return K_ERASE;
      4'h2: return K_SET;
      4'h3: return K_READ;
      4'h5: return K_CLR;
      4'h8, 4'h9, 4'hA, 4'hB, 4'hC: return K_REG;
      4'h6, 4'h7, 4'hD, 4'hE, 4'hF: return K_LOAD;
      default: return K_NONE;
    endcase
  endfunction

  // bit 0 is the first bit received
  function automatic logic preamble_ok(input logic [PRE_W-1:0] b);
    return b[0] & ~b[1] & b[2] & ~b[3] & ~b[5];
  endfunction
endpackage

// File: rtl/sercmd_sync.sv
module sercmd_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1, s2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; prev <= '0;
    end else begin
      s1 <= async_i; s2 <= s1; prev <= s2;
    end
  end

  assign lvl_o  = s2;
  assign rise_o = s2 & ~prev;
  assign fall_o = ~s2 & prev;
endmodule

// File: rtl/sercmd_frame.sv
module sercmd_frame
  import sercmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lvl_i,
  input  logic              cs_rise_i,
  input  logic              sclk_rise_i,
  input  logic              dio_i,
  input  logic              lock_i,
  output logic              session_o,
  output logic              reload_o,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  frame_st_t         st;
  logic [3:0]        cnt;
  logic [WORD_W-1:0] sr;
  logic              inhibit;
  logic [PRE_W-1:0]  pre_bits;

  assign pre_bits = {dio_i, sr[WORD_W-1 -: PRE_W-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= F_IDLE; cnt <= '0; sr <= '0; inhibit <= 1'b0;
      session_o <= 1'b0; reload_o <= 1'b0; word_vld_o <= 1'b0; word_o <= '0;
    end else begin
      reload_o   <= 1'b0;
      word_vld_o <= 1'b0;
      if (!cs_lvl_i) begin
        st <= F_IDLE; session_o <= 1'b0; cnt <= '0;
      end else if (cs_rise_i) begin
        st <= F_PRE; cnt <= '0; reload_o <= ~inhibit;
      end else begin
        case (st)
          F_PRE: if (sclk_rise_i) begin
            sr  <= {dio_i, sr[WORD_W-1:1]};
            cnt <= cnt + 4'd1;
            if (cnt == 4'(PRE_W-1)) begin
              cnt <= '0;
              if (preamble_ok(pre_bits)) begin
                st <= F_WORD; session_o <= 1'b1; inhibit <= pre_bits[4];
              end else begin
                st <= F_DEAD;
              end
            end
          end
          F_WORD: if (lock_i) begin
            st <= F_HOLD;
          end else if (sclk_rise_i) begin
            sr  <= {dio_i, sr[WORD_W-1:1]};
            cnt <= cnt + 4'd1;
            if (cnt == 4'(WORD_W-1)) begin
              word_o <= {dio_i, sr[WORD_W-1:1]};
              word_vld_o <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_word_in_session_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |-> session_o);
  assert_session_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(session_o) |-> !$past(cs_lvl_i));
  assert_reload_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reload_o |-> $past(cs_rise_i));
endmodule

// File: rtl/sercmd_decode.sv
module sercmd_decode
  import sercmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              mem_erase_o,
  output logic              mem_set_o,
  output logic              mem_clr_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              reg_wr_o,
  output logic [2:0]        reg_idx_o,
  output logic [DATA_W-1:0] reg_data_o,
  output logic              reg_load_o
);
  cmd_kind_t         kind;
  logic [CODE_W-1:0] code;
  logic [DATA_W-1:0] data;

  assign code = word_i[WORD_W-1 -: CODE_W];
  assign data = word_i[DATA_W-1:0];
  assign kind = classify(code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_erase_o <= 1'b0; mem_set_o <= 1'b0; mem_clr_o <= 1'b0; mem_rd_o <= 1'b0;
      mem_addr_o <= '0; reg_wr_o <= 1'b0; reg_idx_o <= '0; reg_data_o <= '0;
      reg_load_o <= 1'b0;
    end else begin
      mem_erase_o <= word_vld_i && kind == K_ERASE;
      mem_set_o   <= word_vld_i && kind == K_SET;
      mem_clr_o   <= word_vld_i && kind == K_CLR;
      mem_rd_o    <= word_vld_i && kind == K_READ;
      reg_wr_o    <= word_vld_i && kind == K_REG;
      reg_load_o  <= word_vld_i && kind == K_LOAD;
      if (word_vld_i && (kind == K_SET || kind == K_CLR || kind == K_READ))
        mem_addr_o <= data[ADDR_W-1:0];
      if (word_vld_i && kind == K_REG) begin
        reg_idx_o  <= 3'(code - 4'h8);
        reg_data_o <= data;
      end
    end
  end

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_erase_o, mem_set_o, mem_clr_o, mem_rd_o, reg_wr_o, reg_load_o}));
  assert_strobe_needs_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_erase_o | mem_set_o | mem_clr_o | mem_rd_o | reg_wr_o | reg_load_o)
      |-> $past(word_vld_i));
  assert_reg_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> reg_idx_o <= 3'd4);
endmodule

// File: rtl/sercmd_turn.sv
module sercmd_turn #(
  parameter int RD_DLY = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stb_i,
  input  logic sclk_fall_i,
  input  logic cs_lvl_i,
  input  logic mem_bit_i,
  output logic busy_o,
  output logic dio_o,
  output logic dio_oe_o
);
  localparam int CW = $clog2(RD_DLY + 1);
  logic          pend, counting;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; counting <= 1'b0; cnt <= '0; dio_o <= 1'b0; dio_oe_o <= 1'b0;
    end else if (!cs_lvl_i) begin
      pend <= 1'b0; counting <= 1'b0; cnt <= '0; dio_o <= 1'b0; dio_oe_o <= 1'b0;
    end else begin
      if (rd_stb_i) pend <= 1'b1;
      if (pend && sclk_fall_i) begin
        pend <= 1'b0; counting <= 1'b1; cnt <= '0;
      end
      if (counting) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(RD_DLY - 1)) begin
          counting <= 1'b0; dio_oe_o <= 1'b1; dio_o <= mem_bit_i;
        end
      end
    end
  end

  assign busy_o = pend | counting | dio_oe_o;

  assert_oe_off_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_lvl_i |=> !dio_oe_o);
  assert_oe_after_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dio_oe_o) |-> $past(counting));
endmodule

// File: rtl/sercmd_decoder.sv
module sercmd_decoder
  import sercmd_pkg::*;
#(
  parameter int RD_DLY = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              cs_i,
  input  logic              dio_i,
  input  logic              mem_bit_i,
  output logic              dio_o,
  output logic              dio_oe_o,
  output logic              session_o,
  output logic              reload_o,
  output logic              mem_erase_o,
  output logic              mem_set_o,
  output logic              mem_clr_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              reg_wr_o,
  output logic [2:0]        reg_idx_o,
  output logic [DATA_W-1:0] reg_data_o,
  output logic              reg_load_o
);
  logic [2:0] lvl, rise, fall;
  logic       word_vld, busy;
  logic [WORD_W-1:0] word;

  sercmd_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i({dio_i, cs_i, sclk_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  sercmd_frame u_frame (
    .clk(clk), .rst_n(rst_n), .cs_lvl_i(lvl[1]), .cs_rise_i(rise[1]),
    .sclk_rise_i(rise[0]), .dio_i(lvl[2]), .lock_i(busy),
    .session_o(session_o), .reload_o(reload_o),
    .word_vld_o(word_vld), .word_o(word)
  );

  sercmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .word_vld_i(word_vld), .word_i(word),
    .mem_erase_o(mem_erase_o), .mem_set_o(mem_set_o), .mem_clr_o(mem_clr_o),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .reg_wr_o(reg_wr_o),
    .reg_idx_o(reg_idx_o), .reg_data_o(reg_data_o), .reg_load_o(reg_load_o)
  );

  sercmd_turn #(.RD_DLY(RD_DLY)) u_turn (
    .clk(clk), .rst_n(rst_n), .rd_stb_i(mem_rd_o), .sclk_fall_i(fall[0]),
    .cs_lvl_i(lvl[1]), .mem_bit_i(mem_bit_i), .busy_o(busy),
    .dio_o(dio_o), .dio_oe_o(dio_oe_o)
  );

  assert_no_output_outside_session_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dio_oe_o |-> session_o);
endmodule

// File: tb/test_sercmd_decoder.sv
module test_sercmd_decoder;
  localparam int RD_DLY = 40;
  localparam time HALF  = 80ns;

  logic clk = 0, rst_n = 0, sclk = 0, cs = 0, dio = 0;
  logic mem_bit, dio_o, dio_oe, session, reload;
  logic erase, set_s, clr_s, rd_s, reg_wr, reg_load;
  logic [6:0] addr; logic [2:0] idx; logic [11:0] rdata;
  logic mem [128];
  int checks = 0, fails = 0;
  logic [15:0] expq [$];

  always #2ns clk = ~clk;

  assign mem_bit = mem[addr];

  sercmd_decoder #(.RD_DLY(RD_DLY)) i_sercmd_decoder (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_i(cs), .dio_i(dio),
    .mem_bit_i(mem_bit), .dio_o(dio_o), .dio_oe_o(dio_oe), .session_o(session),
    .reload_o(reload), .mem_erase_o(erase), .mem_set_o(set_s), .mem_clr_o(clr_s),
    .mem_rd_o(rd_s), .mem_addr_o(addr), .reg_wr_o(reg_wr), .reg_idx_o(idx),
    .reg_data_o(rdata), .reg_load_o(reg_load)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every strobe cycle pops one expected item
  always @(negedge clk) if (rst_n) begin
    int n;
    logic [15:0] obs;
    n = int'(erase) + int'(set_s) + int'(clr_s) + int'(rd_s) + int'(reg_wr)
        + int'(reg_load) + int'(reload);
    if (n > 1) chk("R11 multi", 16'(n), 16'd1);
    if (n != 0) begin
      obs = erase ? 16'h1000 : set_s ? {4'h2, 5'h0, addr} : rd_s ? {4'h3, 5'h0, addr}
          : clr_s ? {4'h5, 5'h0, addr} : reg_wr ? {4'(4'h8 + idx), rdata}
          : reg_load ? 16'h6000 : 16'hE000;
      if (expq.size() == 0) chk("R7/R11 unexpected strobe", obs, 16'h0000);
      else chk("R4-strobe", obs, expq.pop_front());
    end
  end

  task automatic bit_out(input logic b);
    dio = b; #HALF; sclk = 1; #HALF; sclk = 0;
  endtask

  task automatic word_out(input logic [3:0] code, input logic [11:0] d);
    logic [15:0] w;
    w = {code, d};
    for (int i = 0; i < 16; i++) bit_out(w[i]);
  endtask

  task automatic preamble(input logic u);
    bit_out(1); bit_out(0); bit_out(1); bit_out(0); bit_out(u); bit_out(0);
  endtask

  task automatic cs_up(input logic exp_reload);
    if (exp_reload) expq.push_back(16'hE000);
    cs = 1; #200ns;
  endtask

  task automatic cs_down();
    #200ns; cs = 0; #200ns;
  endtask

  task automatic drain(input string req);
    #200ns;
    chk(req, 16'(expq.size()), 16'd0);
    expq.delete();
  endtask

  task automatic cmd(input logic [3:0] code, input logic [11:0] d, input logic [15:0] item, input logic exp);
    if (exp) expq.push_back(item);
    word_out(code, d);
  endtask

  initial begin
    #400us;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 1'b0;
    mem[42] = 1'b1;
    #50ns;
    // R1
    chk("R1 outputs", {dio_o, dio_oe, session, reload, erase, set_s, clr_s, rd_s, reg_wr, reg_load}, 16'h0);
    rst_n = 1; #100ns;

    // R3 first rise after reset reloads; R10 session
    cs_up(1);
    preamble(0);
    #40ns chk("R10 session up", 16'(session), 16'd1);
    // R5 memory commands, upper data bits ignored
    cmd(4'h1, 12'hABC, 16'h1000, 1);
    cmd(4'h2, 12'hF85, 16'h2005, 1);
    cmd(4'h5, 12'h07F, 16'h507F, 1);
    // R6 register writes
    cmd(4'h8, 12'h123, 16'h8123, 1);
    cmd(4'h9, 12'hFFF, 16'h9FFF, 1);
    cmd(4'hA, 12'h800, 16'hA800, 1);
    cmd(4'hB, 12'h001, 16'hB001, 1);
    cmd(4'hC, 12'h5A5, 16'hC5A5, 1);
    // R6 loads
    cmd(4'h6, 12'h111, 16'h6000, 1);
    cmd(4'h7, 12'h222, 16'h6000, 1);
    cmd(4'hD, 12'h333, 16'h6000, 1);
    cmd(4'hE, 12'h444, 16'h6000, 1);
    cmd(4'hF, 12'h555, 16'h6000, 1);
    // R7 no-op and reserved
    cmd(4'h0, 12'hFFF, 16'h0, 0);
    cmd(4'h4, 12'h07F, 16'h0, 0);
    drain("R4 all words seen");
    // R9 partial word discarded
    for (int i = 0; i < 7; i++) bit_out(1'b1);
    cs_down();
    chk("R9 session down", 16'(session), 16'd0);
    drain("R9 partial dropped");

    // R2 bad preamble locks the session
    cs_up(1);
    bit_out(1); bit_out(1); bit_out(1); bit_out(0); bit_out(0); bit_out(0);
    cmd(4'h1, 12'h000, 16'h0, 0);
    cmd(4'h8, 12'h0AA, 16'h0, 0);
    chk("R2 session stays low", 16'(session), 16'd0);
    cs_down();
    drain("R2 no strobes");

    // R3 flag U=1 suppresses next reload
    cs_up(1);
    preamble(1);
    cmd(4'hB, 12'hC3C, 16'hBC3C, 1);
    cs_down();
    drain("R3 U=1 session");
    cs_up(0);
    preamble(0);
    cs_down();
    drain("R3 no reload after U=1");
    cs_up(1);
    drain("R3 reload after U=0");

    // R8 read of a set bit
    preamble(0);
    cmd(4'h3, 12'hFAA, 16'h302A, 1);
    #(RD_DLY * 2ns);
    chk("R8 oe not yet", 16'(dio_oe), 16'd0);
    #(RD_DLY * 4ns + 40ns);
    chk("R8 oe up", 16'(dio_oe), 16'd1);
    chk("R8 data one", 16'(dio_o), 16'd1);
    cs_down();
    chk("R9 oe released", 16'(dio_oe), 16'd0);
    drain("R8 read strobe");

    // R8 read of a clear bit
    cs_up(1);
    preamble(0);
    cmd(4'h3, 12'h011, 16'h3011, 1);
    #(RD_DLY * 4ns + 120ns);
    chk("R8 oe up 2", 16'(dio_oe), 16'd1);
    chk("R8 data zero", 16'(dio_o), 16'd0);
    cs_down();
    drain("R8 second read");

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule